// File: doc/BRIEF.md
# GPIO port with edge interrupt events

This block is a 32-pin general-purpose I/O port that a host controls through a simple 32-bit register bus. Each pin has one bit in every register. A direction register chooses between input and output for each pin. A data register drives the output pins. The input pins are resynchronised to the block clock before any other logic uses them.

Every pin has an edge detector. A per-pin control bit sets the detector to react to falling edges only, or to both rising and falling edges. A detected edge latches a pending event bit for that pin. The host clears an event by writing a one to it. A mask register selects which pending events may drive the single combined interrupt request.

Host accesses take effect on a clock edge. A read request is sampled on a rising clock edge, and its data appears on the read-data output from that edge on. There is no state machine. The register file reacts on every cycle in which the select input is high, and it does nothing in any other cycle.

Top module: `gpio_port`

## Requirements
- R1: After reset every register is zero, pin_oe and pin_out are all zero, and irq is low. Reading any register then returns zero.
- R2: Writing byte offset 0x00 sets the direction register, and pin_oe follows it on the next cycle. A 1 bit makes that pin an output. pin_out always shows the data register at byte offset 0x08.
- R3: A read of byte offset 0x08 returns the data register bit for each output pin and the synchronised pad level for each input pin.
- R4: When a pin's edge-control bit (byte offset 0x14) is 0, both a rising and a falling edge on that pin set its event bit. The event bit appears three clock edges after the pin changes: two synchroniser flops, then the event latch.
- R5: When a pin's edge-control bit is 1, only a falling edge sets its event bit. A rising edge leaves the event bit unchanged.
- R6: Writing byte offset 0x0C clears each event bit whose write-data bit is 1. Event bits whose write-data bit is 0 keep their value.
- R7: irq is high exactly while some pin has both its event bit and its mask bit (byte offset 0x10) set to 1. Pending events whose mask bit is 0 do not raise irq.
- R8: Writing all ones to the event register and then zero to the mask register leaves irq low.
- R9: If an edge is detected on a pin in the same cycle that a clearing write hits that pin's event bit, the event bit stays set.
- R10: Byte offset 0x04 always reads as zero, and writes to it have no effect. Unmapped offsets (0x18, 0x1C) and addresses that are not word aligned also read as zero.
- R11: Read data appears on bus_rdata at the clock edge that samples the read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Output data for the pads |
| pin_oe | output | 32 | Output enable per pin (1 = drive) |
| irq | output | 1 | Combined masked interrupt request |

## Verification
The pad inputs are driven with a multi-bit pattern that contains both rising and falling transitions. The bench then toggles single pins in both edge modes, so a falling-only pin that reacts to a rising edge stands out from one in both-edges mode. Data reads use a direction mix in which the pad levels and the data register differ on the output pins, which shows whether the read mux selects per pin. The interrupt is checked against masks that cover the pending pin and masks that miss it. Clearing writes are tried with a zero write, with a matching write, and with a write timed to land on the same edge as a new detection.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Word index of each register (byte offset / 4)
    typedef enum logic [2:0] {
        REG_DIR = 3'd0,
        REG_ODR = 3'd1,
        REG_DAT = 3'd2,
        REG_EVT = 3'd3,
        REG_MSK = 3'd4,
        REG_EDG = 3'd5
    } reg_idx_e;

endpackage

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [N_PINS-1:0] fall_only,
    output logic [N_PINS-1:0] pad_sync,
    output logic [N_PINS-1:0] hit
);

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic meta_q;
        logic sync_q;
        logic prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_in[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        logic rise;
        logic fall;
        assign rise        = sync_q & ~prev_q;
        assign fall        = ~sync_q & prev_q;
        assign hit[i]      = fall | (rise & ~fall_only[i]);
        assign pad_sync[i] = sync_q;
    end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_port_pkg::*;
#(
    parameter int N_PINS = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    input  logic [N_PINS-1:0] pad_sync,
    input  logic [N_PINS-1:0] hit,
    output logic [N_PINS-1:0] bus_rdata,
    output logic [N_PINS-1:0] dir_q,
    output logic [N_PINS-1:0] dat_q,
    output logic [N_PINS-1:0] ev_q,
    output logic [N_PINS-1:0] msk_q,
    output logic [N_PINS-1:0] edg_q
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             wr_en;
    logic             rd_en;
    logic [N_PINS-1:0] clr_mask;
    logic [N_PINS-1:0] rd_mux;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_en   = bus_sel & bus_wr & aligned;
    assign rd_en   = bus_sel & ~bus_wr;

    assign clr_mask = (wr_en && idx == IDX_W'(REG_EVT)) ? bus_wdata : '0;

    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            case (idx)
                IDX_W'(REG_DIR): rd_mux = dir_q;
                IDX_W'(REG_ODR): rd_mux = '0;
                IDX_W'(REG_DAT): rd_mux = (dat_q & dir_q) | (pad_sync & ~dir_q);
                IDX_W'(REG_EVT): rd_mux = ev_q;
                IDX_W'(REG_MSK): rd_mux = msk_q;
                IDX_W'(REG_EDG): rd_mux = edg_q;
                default:         rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q     <= '0;
            dat_q     <= '0;
            ev_q      <= '0;
            msk_q     <= '0;
            edg_q     <= '0;
            bus_rdata <= '0;
        end else begin
            if (wr_en && idx == IDX_W'(REG_DIR)) dir_q <= bus_wdata;
            if (wr_en && idx == IDX_W'(REG_DAT)) dat_q <= bus_wdata;
            if (wr_en && idx == IDX_W'(REG_MSK)) msk_q <= bus_wdata;
            if (wr_en && idx == IDX_W'(REG_EDG)) edg_q <= bus_wdata;
            // a fresh edge outranks a clearing write on the same bit
            ev_q <= (ev_q & ~clr_mask) | hit;
            if (rd_en) bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int N_PINS = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq
);

    logic [N_PINS-1:0] pad_sync;
    logic [N_PINS-1:0] edge_hit;
    logic [N_PINS-1:0] dir_q;
    logic [N_PINS-1:0] dat_q;
    logic [N_PINS-1:0] ev_q;
    logic [N_PINS-1:0] msk_q;
    logic [N_PINS-1:0] edg_q;

    gpio_edge_det #(.N_PINS(N_PINS)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .fall_only (edg_q),
        .pad_sync  (pad_sync),
        .hit       (edge_hit)
    );

    gpio_regfile #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pad_sync  (pad_sync),
        .hit       (edge_hit),
        .bus_rdata (bus_rdata),
        .dir_q     (dir_q),
        .dat_q     (dat_q),
        .ev_q      (ev_q),
        .msk_q     (msk_q),
        .edg_q     (edg_q)
    );

    assign pin_out = dat_q;
    assign pin_oe  = dir_q;
    assign irq     = |(ev_q & msk_q);

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int N_PINS = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N_PINS-1:0] bus_wdata,
    input logic [N_PINS-1:0] pin_oe,
    input logic              irq,
    input logic [N_PINS-1:0] ev_q,
    input logic [N_PINS-1:0] msk_q,
    input logic [N_PINS-1:0] hit
);

    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'({REG_DIR, 2'b00});
    localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'({REG_EVT, 2'b00});
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'({REG_MSK, 2'b00});

    logic wr_dir, wr_evt_all, wr_msk_zero;
    assign wr_dir      = bus_sel && bus_wr && bus_addr == A_DIR;
    assign wr_evt_all  = bus_sel && bus_wr && bus_addr == A_EVT && (&bus_wdata);
    assign wr_msk_zero = bus_sel && bus_wr && bus_addr == A_MSK && bus_wdata == '0;

    a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> pin_oe == $past(bus_wdata));

    a_r8_mask_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wr_msk_zero |=> !irq);

    a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt_all && hit == '0) |=> ev_q == '0);

    a_r9_edge_sets_event: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((ev_q & $past(hit)) == $past(hit)));

    a_r4_no_spurious_event: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_q & ~$past(ev_q) & ~$past(hit)) == '0);

    a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (msk_q != '0));

endmodule

bind gpio_port gpio_port_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .ev_q      (ev_q),
    .msk_q     (msk_q),
    .hit       (edge_hit)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;

    localparam int N = 32;
    localparam logic [4:0] O_DIR = 5'h00, O_ODR = 5'h04, O_DAT = 5'h08,
                           O_EVT = 5'h0C, O_MSK = 5'h10, O_EDG = 5'h14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [N-1:0] exp_q[$];
    string        tag_q[$];
    logic         rd_seen = 1'b0;

    always #10 clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // driver: issues the read and pushes the expected value
    task automatic bus_read(input logic [4:0] a, input logic [N-1:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // monitor: R11, read data present after the sampling edge
    always @(posedge clk) rd_seen <= bus_sel && !bus_wr;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11: unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [N-1:0] dirv, datv;
        dirv = 32'h0000_FF00;
        datv = 32'hA5A5_5A5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 pin_oe", pin_oe, '0);
        check("R1 pin_out", pin_out, '0);
        check("R1 irq", {31'b0, irq}, '0);
        rst_n = 1'b1;
        bus_read(O_DIR, '0, "R1 dir");
        bus_read(O_DAT, '0, "R1 dat");
        bus_read(O_EVT, '0, "R1 evt");
        bus_read(O_MSK, '0, "R1 msk");
        bus_read(O_EDG, '0, "R1 edg");
        bus_read(5'h18, '0, "R10 unmapped");

        // R8 init sequence
        bus_write(O_EVT, '1);
        bus_write(O_MSK, '0);
        check("R8 irq after init", {31'b0, irq}, '0);

        // R2 direction and output data
        bus_write(O_DIR, dirv);
        bus_write(O_DAT, datv);
        check("R2 pin_oe", pin_oe, dirv);
        check("R2 pin_out", pin_out, datv);
        bus_write(O_ODR, '1);
        bus_read(O_ODR, '0, "R10 odr reads zero");
        bus_read(O_DIR, dirv, "R10 dir after odr write");
        bus_read(5'h09, '0, "R10 misaligned");

        // R3 mixed read, R4 multi-pin both-edge events
        @(negedge clk) pin_in = 32'h1234_5678;
        settle();
        bus_read(O_DAT, (datv & dirv) | (32'h1234_5678 & ~dirv), "R3 data mix");
        bus_read(O_EVT, 32'h1234_5678, "R4 multi-pin events");
        bus_write(O_EVT, '1);
        bus_read(O_EVT, '0, "R6 clear all");

        // R5 falling-only on pin 3
        bus_write(O_EDG, 32'h8);
        @(negedge clk) pin_in = 32'h1234_5670;
        settle();
        bus_read(O_EVT, 32'h8, "R5 falling sets");
        check("R7 masked off", {31'b0, irq}, '0);
        bus_write(O_MSK, 32'h10);
        check("R7 other mask", {31'b0, irq}, '0);
        bus_write(O_MSK, 32'h8);
        check("R7 mask on", {31'b0, irq}, 32'h1);
        bus_write(O_EVT, '0);
        bus_read(O_EVT, 32'h8, "R6 zero write no effect");
        check("R6 irq kept", {31'b0, irq}, 32'h1);
        bus_write(O_EVT, 32'h8);
        check("R6 irq after clear", {31'b0, irq}, '0);
        @(negedge clk) pin_in = 32'h1234_5678;
        settle();
        bus_read(O_EVT, '0, "R5 rising ignored");

        // R4 single pin both directions (pin 4)
        @(negedge clk) pin_in = 32'h1234_5668;
        settle();
        bus_read(O_EVT, 32'h10, "R4 falling");
        bus_write(O_EVT, 32'h10);
        @(negedge clk) pin_in = 32'h1234_5678;
        settle();
        bus_read(O_EVT, 32'h10, "R4 rising");
        bus_write(O_EVT, 32'h10);

        // R9 edge and clear on the same edge
        bus_write(O_MSK, 32'h10);
        @(negedge clk) pin_in = 32'h1234_5668;
        repeat (2) @(posedge clk);
        bus_write(O_EVT, 32'h10);
        check("R9 irq held", {31'b0, irq}, 32'h1);
        bus_read(O_EVT, 32'h10, "R9 event held");

        // R8 again with an event pending
        bus_write(O_EVT, '1);
        bus_write(O_MSK, '0);
        check("R8 irq low", {31'b0, irq}, '0);

        repeat (3) @(negedge clk);
        check("R11 queue drained", 32'(exp_q.size()), '0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule